// File: doc/BRIEF.md
# Wiper Register Command Decoder

This block sits behind a serial front end that has already split each frame into a 4-bit command code and a 10-bit data field and presents them as a one-cycle strobe. It holds the 10-bit wiper position of a digital rheostat, three control bits (wiper write enable, memory program enable and a read-only store-success flag), a shutdown flag and the address of the most recently programmed memory slot. Each accepted command updates this state and prepares the 16-bit word that the front end shifts out during the following frame.

Stores, restores and memory reads are passed to a nonvolatile-memory sequencer through a request/acknowledge pair. The request stays high with a stable operation and address until the sequencer acknowledges it. A store also reports success or failure. While the sequencer signals busy, or while a request is still outstanding, incoming commands change nothing except the echoed readback word.

Top module: `wiper_cmd_decoder`

## Requirements
- R1: After reset the wiper is 0x200 (midscale), shutdown is 0, all three control bits are 0, the slot counter is 0, the readback word is 0 and no memory request is pending.
- R2: Command 1 loads the wiper from the 10 data bits only when the write-enable bit (control bit 1) is 1. Otherwise the wiper is unchanged.
- R3: Command 7 sets the write-enable bit from D1 and the program-enable bit from D0, and never alters the success flag. Command 8 makes the next readback word {13'b0, success, writeEnable, programEnable}.
- R4: Command 2 makes the next readback word {6'b0, wiper}. Command 6 makes it {10'b0, slot counter}. Every other frame makes it an echo of the frame, {2'b00, code, data}.
- R5: Command 3 with program enable set and fewer than 50 slots used issues a store request (op 1) at address counter+1 with the wiper as write data. On an acknowledge with success the counter increments and the success flag becomes 1. On a failed acknowledge the flag becomes 0 and the counter is unchanged. Without program enable, or with all 50 slots used, the command is ignored.
- R6: Command 4 clears shutdown regardless of write enable. With a counter of 0 it sets the wiper to midscale at once. Otherwise it issues a restore request (op 2) at the counter address and loads the returned data into the wiper.
- R7: Command 5 issues a read request (op 3) at address D5..D0. The returned data becomes the readback word {6'b0, data} when the acknowledge arrives.
- R8: Command 9 sets shutdown to D0. All commands remain effective while shutdown is 1.
- R9: While the busy input is 1, no command changes the wiper, control bits, shutdown or counter, and none issues a request. The readback word becomes the echo.
- R10: Command codes 0 and 10 to 15 change nothing but the echo.
- R11: Once raised, the memory request stays high with unchanged op and address until the cycle in which the acknowledge is seen, and then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle strobe marking a decoded frame |
| cmdCode | input | 4 | Command code of the frame |
| cmdData | input | 10 | Data field of the frame |
| readWord | output | 16 | Word to be shifted out in the next frame |
| wiper | output | 10 | Current wiper position |
| shutdown | output | 1 | 1 opens the resistor end terminal |
| memReq | output | 1 | Memory request, held until acknowledged |
| memOp | output | 2 | 1 store, 2 restore, 3 read |
| memAddr | output | 6 | Memory slot address of the request |
| memWrData | output | 10 | Data to store |
| memAck | input | 1 | Sequencer completes the pending request |
| memOk | input | 1 | Store succeeded (valid with memAck) |
| memRdData | input | 10 | Data read (valid with memAck) |
| memBusy | input | 1 | Sequencer busy; commands are ignored |

## Verification
Directed frames first walk the protected path: a wiper write before write enable, a restore with no programmed slot, the enabling control write followed by a quarter-scale write, then stores with and without program enable and with a forced failure that must clear the success flag. Constrained random frames then mix every code, including the unused ones, with random data, random acknowledge latency, occasional store failures and periods of forced busy. This separates commands that only echo from those that move the wiper or issue a request. A final run fills all 50 slots and checks that one more store is refused, and that a restore brings back the last stored value rather than midscale.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_WR_WIPER = 4'd1,
    CMD_RD_WIPER = 4'd2,
    CMD_STORE    = 4'd3,
    CMD_RESTORE  = 4'd4,
    CMD_RD_MEM   = 4'd5,
    CMD_RD_LAST  = 4'd6,
    CMD_WR_CTRL  = 4'd7,
    CMD_RD_CTRL  = 4'd8,
    CMD_SHUTDOWN = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    MOP_NONE    = 2'd0,
    MOP_STORE   = 2'd1,
    MOP_RESTORE = 2'd2,
    MOP_READ    = 2'd3
  } memop_e;

  typedef enum logic [2:0] {
    RB_ECHO,
    RB_WIPER,
    RB_CTRL,
    RB_LAST,
    RB_MEM
  } rbsel_e;

  // Strobes from the control half to the register half
  typedef struct packed {
    logic   wiperFromCmd;
    logic   wiperFromMem;
    logic   wiperToMid;
    logic   ctrlLoad;
    logic   shutSet;
    logic   shutClr;
    logic   storeDone;
    logic   storeOk;
    logic   rbLoad;
    rbsel_e rbSel;
  } strobe_t;

endpackage

// File: rtl/wcd_control.sv
module wcd_control
  import wcd_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 6,
  parameter int SLOTS  = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdCode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              memBusy,
  input  logic              memAck,
  input  logic              memOk,
  input  logic [DATA_W-1:0] wiperIn,
  input  logic              wrEn,
  input  logic              prgEn,
  input  logic [ADDR_W-1:0] lastAddr,
  output strobe_t           strb,
  output logic              memReq,
  output logic [1:0]        memOp,
  output logic [ADDR_W-1:0] memAddr
);

  localparam logic [ADDR_W-1:0] SLOT_MAX = ADDR_W'(SLOTS);
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

  cmd_e              code;
  memop_e            opReg;
  logic [ADDR_W-1:0] addrReg;
  logic              busy;
  logic              accept;
  logic              ackNow;
  logic              startReq;
  memop_e            startOp;
  logic [ADDR_W-1:0] startAddr;

  assign code   = cmd_e'(cmdCode);
  assign busy   = memBusy | memReq;
  assign accept = cmdValid & ~busy;
  assign ackNow = memReq & memAck;

  always_comb begin
    strb      = '0;
    strb.rbSel = RB_ECHO;
    startReq  = 1'b0;
    startOp   = MOP_NONE;
    startAddr = '0;

    if (cmdValid && !ackNow) begin
      strb.rbLoad = 1'b1;
    end

    if (accept) begin
      case (code)
        CMD_WR_WIPER: strb.wiperFromCmd = wrEn;
        CMD_RD_WIPER: strb.rbSel = RB_WIPER;
        CMD_STORE: begin
          if (prgEn && (lastAddr < SLOT_MAX)) begin
            startReq  = 1'b1;
            startOp   = MOP_STORE;
            startAddr = lastAddr + ONE;
          end
        end
        CMD_RESTORE: begin
          strb.shutClr = 1'b1;
          if (lastAddr == '0) begin
            strb.wiperToMid = 1'b1;
          end else begin
            startReq  = 1'b1;
            startOp   = MOP_RESTORE;
            startAddr = lastAddr;
          end
        end
        CMD_RD_MEM: begin
          startReq  = 1'b1;
          startOp   = MOP_READ;
          startAddr = cmdAddr;
        end
        CMD_RD_LAST:  strb.rbSel = RB_LAST;
        CMD_WR_CTRL:  strb.ctrlLoad = 1'b1;
        CMD_RD_CTRL:  strb.rbSel = RB_CTRL;
        CMD_SHUTDOWN: begin
          strb.shutSet = cmdAddr[0];
          strb.shutClr = ~cmdAddr[0];
        end
        default: ;
      endcase
    end

    if (ackNow) begin
      case (opReg)
        MOP_STORE: begin
          strb.storeDone = 1'b1;
          strb.storeOk   = memOk;
        end
        MOP_RESTORE: strb.wiperFromMem = 1'b1;
        MOP_READ: begin
          strb.rbLoad = 1'b1;
          strb.rbSel  = RB_MEM;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq  <= 1'b0;
      opReg   <= MOP_NONE;
      addrReg <= '0;
    end else if (startReq) begin
      memReq  <= 1'b1;
      opReg   <= startOp;
      addrReg <= startAddr;
    end else if (ackNow) begin
      memReq  <= 1'b0;
    end
  end

  assign memOp   = opReg;
  assign memAddr = addrReg;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memOp) && $stable(memAddr));

  // R5
  store_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memOp == 2'd1 |-> memAddr != '0 && memAddr <= SLOT_MAX);

  // R2
  wiper_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 4'd1 && !wrEn && !memReq |=> $stable(wiperIn));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && memBusy && !memReq |=> $stable(wiperIn) && !$rose(memReq));

endmodule

// File: rtl/wcd_datapath.sv
module wcd_datapath
  import wcd_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 6,
  parameter int CODE_W = 4,
  parameter int WORD_W = 2 + CODE_W + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] wiper,
  output logic              shutdown,
  output logic              wrEn,
  output logic              prgEn,
  output logic              prgOk,
  output logic [ADDR_W-1:0] lastAddr,
  output logic [WORD_W-1:0] readWord
);

  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic [WORD_W-1:0] rbNext;

  always_comb begin
    case (strb.rbSel)
      RB_WIPER: rbNext = WORD_W'(wiper);
      RB_CTRL:  rbNext = WORD_W'({prgOk, wrEn, prgEn});
      RB_LAST:  rbNext = WORD_W'(lastAddr);
      RB_MEM:   rbNext = WORD_W'(memRdData);
      default:  rbNext = WORD_W'({cmdCode, cmdData});
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wiper    <= MID;
      shutdown <= 1'b0;
      wrEn     <= 1'b0;
      prgEn    <= 1'b0;
      prgOk    <= 1'b0;
      lastAddr <= '0;
      readWord <= '0;
    end else begin
      if (strb.wiperFromCmd)      wiper <= cmdData;
      else if (strb.wiperFromMem) wiper <= memRdData;
      else if (strb.wiperToMid)   wiper <= MID;

      if (strb.shutSet)      shutdown <= 1'b1;
      else if (strb.shutClr) shutdown <= 1'b0;

      if (strb.ctrlLoad) begin
        wrEn  <= cmdData[1];
        prgEn <= cmdData[0];
      end

      if (strb.storeDone) begin
        prgOk <= strb.storeOk;
        if (strb.storeOk) lastAddr <= lastAddr + ADDR_W'(1);
      end

      if (strb.rbLoad) readWord <= rbNext;
    end
  end

  // R3
  ok_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlLoad |=> $stable(prgOk));

endmodule

// File: rtl/wiper_cmd_decoder.sv
module wiper_cmd_decoder
  import wcd_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 6,
  parameter int SLOTS  = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdData,
  output logic [DATA_W+5:0] readWord,
  output logic [DATA_W-1:0] wiper,
  output logic              shutdown,
  output logic              memReq,
  output logic [1:0]        memOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memAck,
  input  logic              memOk,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memBusy
);

  localparam int CODE_W = 4;

  strobe_t           strb;
  logic              wrEn;
  logic              prgEn;
  logic              prgOk;
  logic [ADDR_W-1:0] lastAddr;

  wcd_control #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .cmdAddr  (cmdData[ADDR_W-1:0]),
    .memBusy  (memBusy),
    .memAck   (memAck),
    .memOk    (memOk),
    .wiperIn  (wiper),
    .wrEn     (wrEn),
    .prgEn    (prgEn),
    .lastAddr (lastAddr),
    .strb     (strb),
    .memReq   (memReq),
    .memOp    (memOp),
    .memAddr  (memAddr)
  );

  wcd_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdCode   (cmdCode),
    .cmdData   (cmdData),
    .memRdData (memRdData),
    .wiper     (wiper),
    .shutdown  (shutdown),
    .wrEn      (wrEn),
    .prgEn     (prgEn),
    .prgOk     (prgOk),
    .lastAddr  (lastAddr),
    .readWord  (readWord)
  );

  assign memWrData = wiper;

endmodule

// File: tb/test_wiper_cmd_decoder.sv
module test_wiper_cmd_decoder;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [3:0]  cmdCode;
  logic [9:0]  cmdData;
  logic [15:0] readWord;
  logic [9:0]  wiper;
  logic        shutdown;
  logic        memReq;
  logic [1:0]  memOp;
  logic [5:0]  memAddr;
  logic [9:0]  memWrData;
  logic        memAck;
  logic        memOk;
  logic [9:0]  memRdData;
  logic        memBusy;

  int nChecks = 0;
  int nErr    = 0;
  logic failNext = 1'b0;

  logic [9:0] memArr [64];
  logic [9:0] eMem   [64];
  logic [9:0] eWiper;
  logic       eShut, eWe, ePe, eOk;
  logic [5:0] eLast;
  logic [15:0] eWord;

  always #4 clk = ~clk;

  wiper_cmd_decoder i_wiper_cmd_decoder (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdData(cmdData),
    .readWord(readWord), .wiper(wiper), .shutdown(shutdown), .memReq(memReq),
    .memOp(memOp), .memAddr(memAddr), .memWrData(memWrData), .memAck(memAck),
    .memOk(memOk), .memRdData(memRdData), .memBusy(memBusy)
  );

  function automatic logic [9:0] pat(input int i);
    return 10'((i * 37 + 5) % 1024);
  endfunction

  function automatic string tagFor(input logic [3:0] c, input logic busyNow);
    if (busyNow) return "R9";
    case (c)
      4'd1: return "R2";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6: return "R4";
      4'd7: return "R3";
      4'd8: return "R3";
      4'd9: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Memory sequencer model
  initial begin : seq
    int lat;
    memAck = 1'b0; memOk = 1'b0; memRdData = '0;
    for (int i = 0; i < 64; i++) memArr[i] = pat(i);
    forever begin
      @(negedge clk);
      if (memReq) begin
        lat = $urandom_range(0, 4);
        repeat (lat) @(negedge clk);
        if (memOp == 2'd1) begin
          memOk = ~failNext;
          if (!failNext) memArr[memAddr] = memWrData;
        end else begin
          memRdData = memArr[memAddr];
        end
        memAck = 1'b1;
        @(negedge clk);
        memAck = 1'b0;
      end
    end
  end

  // Reference model of one frame, from the requirements
  task automatic modelStep(input logic [3:0] c, input logic [9:0] d);
    eWord = {2'b00, c, d};
    if (!memBusy) begin
      case (c)
        4'd1: if (eWe) eWiper = d;
        4'd2: eWord = {6'b0, eWiper};
        4'd3: if (ePe && eLast < 6'd50) begin
          eOk = ~failNext;
          if (!failNext) begin
            eLast = eLast + 6'd1;
            eMem[eLast] = eWiper;
          end
        end
        4'd4: begin
          eShut = 1'b0;
          eWiper = (eLast == 0) ? 10'h200 : eMem[eLast];
        end
        4'd5: eWord = {6'b0, eMem[d[5:0]]};
        4'd6: eWord = {10'b0, eLast};
        4'd7: begin eWe = d[1]; ePe = d[0]; end
        4'd8: eWord = {13'b0, eOk, eWe, ePe};
        4'd9: eShut = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic frame(input logic [3:0] c, input logic [9:0] d);
    string tag;
    logic expReq;
    logic [1:0] expOp;
    logic [5:0] expAddr;
    tag = tagFor(c, memBusy);
    expReq = !memBusy && ((c == 4'd3 && ePe && eLast < 6'd50) ||
                          (c == 4'd4 && eLast != 0) || c == 4'd5);
    expOp   = (c == 4'd3) ? 2'd1 : (c == 4'd4) ? 2'd2 : 2'd3;
    expAddr = (c == 4'd3) ? eLast + 6'd1 : (c == 4'd4) ? eLast : d[5:0];
    @(negedge clk);
    cmdCode = c; cmdData = d; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(tag, "memReq", 32'(memReq), 32'(expReq));
    if (expReq && memReq) begin
      chk(tag, "memOp", 32'(memOp), 32'(expOp));
      chk(tag, "memAddr", 32'(memAddr), 32'(expAddr));
      if (c == 4'd3) chk("R5", "memWrData", 32'(memWrData), 32'(eWiper));
      while (memReq) begin
        @(negedge clk);
        if (memReq) chk("R11", "memOp held", 32'(memOp), 32'(expOp));
      end
    end
    modelStep(c, d);
    chk(tag, "wiper", 32'(wiper), 32'(eWiper));
    chk(tag, "shutdown", 32'(shutdown), 32'(eShut));
    chk(tag, "readWord", 32'(readWord), 32'(eWord));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
    $finish;
  end

  initial begin : main
    logic [3:0] c;
    logic [9:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) eMem[i] = pat(i);
    eWiper = 10'h200; eShut = 0; eWe = 0; ePe = 0; eOk = 0; eLast = 0; eWord = 0;
    rstN = 1'b0; cmdValid = 1'b0; cmdCode = '0; cmdData = '0; memBusy = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "wiper", 32'(wiper), 32'h200);
    chk("R1", "shutdown", 32'(shutdown), 0);
    chk("R1", "readWord", 32'(readWord), 0);
    chk("R1", "memReq", 32'(memReq), 0);

    frame(4'd8, 10'h000);          // R3 control defaults read 0
    frame(4'd1, 10'h155);          // R2 protected write ignored
    frame(4'd9, 10'h001);          // R8 enter shutdown
    frame(4'd4, 10'h000);          // R6 restore, empty: midscale, shutdown cleared
    frame(4'd7, 10'h003);          // R3 enable both
    frame(4'd1, 10'h100);          // R2 quarter scale
    frame(4'd2, 10'h000);          // R4 wiper readback
    frame(4'd3, 10'h000);          // R5 store
    frame(4'd6, 10'h000);          // R4 last address
    frame(4'd8, 10'h000);          // R3 success flag
    frame(4'd7, 10'h002);          // R3 program disabled
    frame(4'd3, 10'h000);          // R5 ignored
    frame(4'd7, 10'h3FF);          // R3 only D1..D0 matter
    failNext = 1'b1;
    frame(4'd3, 10'h000);          // R5 failed store
    failNext = 1'b0;
    frame(4'd8, 10'h000);          // R3 flag cleared
    frame(4'd9, 10'h001);          // R8
    frame(4'd1, 10'h3FF);          // R8 commands work in shutdown
    frame(4'd9, 10'h000);
    frame(4'd12, 10'h2AB);         // R10
    frame(4'd15, 10'h3FF);         // R10
    frame(4'd5, 10'h001);          // R7 read slot 1
    frame(4'd5, 10'h03A);          // R7 unprogrammed slot
    frame(4'd1, 10'h02A);
    frame(4'd4, 10'h000);          // R6 restore from slot

    memBusy = 1'b1;                // R9
    for (int k = 1; k < 10; k++) frame(4'(k), 10'h3C1);
    memBusy = 1'b0;

    for (int n = 0; n < 600; n++) begin
      c = 4'($urandom_range(0, 15));
      d = 10'($urandom_range(0, 1023));
      failNext = ($urandom_range(0, 7) == 0);
      memBusy  = ($urandom_range(0, 9) == 0);
      frame(c, d);
      memBusy  = 1'b0;
    end
    failNext = 1'b0;

    frame(4'd7, 10'h003);
    while (eLast < 6'd50) begin
      frame(4'd1, 10'($urandom_range(0, 1023)));
      frame(4'd3, 10'h000);        // R5 fill
    end
    frame(4'd1, 10'h011);
    frame(4'd3, 10'h000);          // R5 full: ignored
    frame(4'd6, 10'h000);          // R4 counter stays 50
    frame(4'd4, 10'h000);          // R6 restore last slot

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule